// File: doc/BRIEF.md
# Acquire/Release Access Ordering Gate

This block sits between a stream of memory requests and a memory port and decides, one request at a time, whether the request at the head of the stream may issue now. Every request carries a kind: an ordinary load or store, a full synchronization, an acquire or a release. The gate counts the accesses it has issued that memory has not yet acknowledged. It also remembers whether a blocking operation or a release is still in flight. From that state it raises or lowers `req_ready`.

A mode input selects one of two rule sets. In weak-ordering mode every synchronizing kind behaves as a full fence. It waits until nothing is outstanding, and nothing may pass it until it is acknowledged. In release mode an acquire holds back only the accesses that follow it. A release waits only for the accesses that precede it, and ordinary accesses that follow a release may go ahead of it, so critical sections can overlap. The gate never reorders requests. A request that may not issue waits at the head with `req_ready` low.

Top module: `ordgate`

## Requirements
- R1: After reset nothing is outstanding and no blocking operation is pending, so a request of any kind is accepted at once while `mem_ready` is high.
- R2: Kind codes are 2'b00 ordinary, 2'b01 sync, 2'b10 acquire and 2'b11 release. An ordinary request issues whenever no blocking operation is pending and the outstanding count is below `MAX_OUT`, no matter how many earlier accesses are still unacknowledged.
- R3: When `mode_rel` is 0, sync, acquire and release requests issue only when the outstanding count is zero.
- R4: A sync (either mode), or any non-ordinary kind in weak mode, or an acquire in release mode, blocks every later request until a completion arrives on `ack_valid` with a non-ordinary `ack_kind` (codes as in R2).
- R5: When `mode_rel` is 1, an acquire issues even if earlier ordinary accesses are outstanding, provided that no release is pending.
- R6: When `mode_rel` is 1, a release or a sync issues only when the outstanding count is zero.
- R7: When `mode_rel` is 1, ordinary requests that follow an issued release may issue before that release is acknowledged. An acquire may not issue until the release is acknowledged.
- R8: The outstanding count saturates at `MAX_OUT`. At that value no request issues until an acknowledge arrives.
- R9: An acknowledge that arrives while the outstanding count is zero is ignored, and the count stays at zero.
- R10: `iss_valid` equals `req_valid` gated by the ordering rules alone. `req_ready` additionally requires `mem_ready`, and `iss_kind` carries `req_kind`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rel | input | 1 | 0 selects weak ordering, 1 selects release consistency |
| req_valid | input | 1 | Head request present |
| req_kind | input | 2 | Kind of the head request |
| req_ready | output | 1 | Head request is taken this cycle |
| iss_valid | output | 1 | Request offered to memory |
| iss_kind | output | 2 | Kind of the offered request |
| mem_ready | input | 1 | Memory accepts the offered request |
| ack_valid | input | 1 | One issued access has completed |
| ack_kind | input | 2 | Kind of the completed access |

## Verification
The main vector walk runs the same kinds under both modes, so each stall separates one rule set from the other. A sync held back by two ordinary accesses shows the drain of earlier accesses. Ordinary requests stacked behind an acquire or a sync show the blocking of later accesses. In release mode, an acquire that is accepted with an ordinary access still outstanding, and an ordinary access that is accepted behind an unacknowledged release, tell the relaxed rules apart from full fencing. Directed tests then fill the counter to its limit, send acknowledges while nothing is outstanding, and drop `mem_ready`.

// File: rtl/ordgate_pkg.sv
package ordgate_pkg;
  typedef enum logic [1:0] {
    K_ORD  = 2'b00,
    K_SYNC = 2'b01,
    K_ACQ  = 2'b10,
    K_REL  = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/ordgate_rules.sv
module ordgate_rules
  import ordgate_pkg::*;
(
  input  logic      mode_rel,
  input  acc_kind_e kind,
  input  logic      cnt_zero,
  input  logic      cnt_full,
  input  logic      blk_pend,
  input  logic      rel_pend,
  output logic      allow,
  output logic      sets_blk,
  output logic      sets_rel
);
  logic fence_kind;

  always_comb begin
    fence_kind = (kind == K_SYNC) || (!mode_rel && kind != K_ORD);
    sets_blk   = fence_kind || (mode_rel && kind == K_ACQ);
    sets_rel   = mode_rel && (kind == K_REL);
    allow      = !blk_pend && !cnt_full;
    if (fence_kind) begin
      allow = allow && cnt_zero;
    end else if (kind == K_REL) begin
      allow = allow && cnt_zero;
    end else if (kind == K_ACQ) begin
      allow = allow && !rel_pend;
    end
  end
endmodule

// File: rtl/ordgate_tracker.sv
module ordgate_tracker
  import ordgate_pkg::*;
#(
  parameter int MAX_OUT = 16,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             set_blk,
  input  logic             set_rel,
  input  logic             ack_valid,
  input  acc_kind_e        ack_kind,
  output logic [CNT_W-1:0] cnt_q,
  output logic             blk_q,
  output logic             rel_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  logic [CNT_W-1:0] cnt_d;
  logic             blk_d, rel_d;
  logic             dec, sync_done, en;

  always_comb begin
    dec       = ack_valid && (cnt_q != '0);
    sync_done = dec && (ack_kind != K_ORD);
    cnt_d     = cnt_q;
    if (fire && !dec && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else if (!fire && dec)                cnt_d = cnt_q - 1'b1;
    blk_d = blk_q;
    rel_d = rel_q;
    if (sync_done) begin
      blk_d = 1'b0;
      rel_d = 1'b0;
    end
    if (fire && set_blk) blk_d = 1'b1;
    if (fire && set_rel) rel_d = 1'b1;
    en = fire || dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
      rel_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      blk_q <= blk_d;
      rel_q <= rel_d;
    end
  end
endmodule

// File: rtl/ordgate.sv
module ordgate
  import ordgate_pkg::*;
#(
  parameter int MAX_OUT = 16,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_rel,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  output logic       req_ready,
  output logic       iss_valid,
  output logic [1:0] iss_kind,
  input  logic       mem_ready,
  input  logic       ack_valid,
  input  logic [1:0] ack_kind
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  logic [CNT_W-1:0] cnt_q;
  logic blk_q, rel_q, allow, sets_blk, sets_rel, fire;

  ordgate_rules u_rules (
    .mode_rel (mode_rel),
    .kind     (acc_kind_e'(req_kind)),
    .cnt_zero (cnt_q == '0),
    .cnt_full (cnt_q == CNT_MAX),
    .blk_pend (blk_q),
    .rel_pend (rel_q),
    .allow    (allow),
    .sets_blk (sets_blk),
    .sets_rel (sets_rel)
  );

  always_comb begin
    req_ready = allow && mem_ready;
    iss_valid = req_valid && allow;
    iss_kind  = req_kind;
    fire      = req_valid && req_ready;
  end

  ordgate_tracker #(.MAX_OUT(MAX_OUT)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .set_blk   (sets_blk),
    .set_rel   (sets_rel),
    .ack_valid (ack_valid),
    .ack_kind  (acc_kind_e'(ack_kind)),
    .cnt_q     (cnt_q),
    .blk_q     (blk_q),
    .rel_q     (rel_q)
  );
endmodule

// File: rtl/ordgate_chk.sv
module ordgate_chk #(
  parameter int MAX_OUT = 16,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
)(
  input logic             clk,
  input logic             rst_n,
  input logic             mode_rel,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic             req_ready,
  input logic             mem_ready,
  input logic             ack_valid,
  input logic [CNT_W-1:0] cnt,
  input logic             blk,
  input logic             rel
);
  assert_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> !req_ready);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(MAX_OUT)) |-> !req_ready);
  assert_rel_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rel && req_kind == 2'b11 && req_ready) |-> (cnt == '0));
  assert_weak_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rel && req_kind != 2'b00 && req_ready) |-> (cnt == '0));
  assert_acq_after_rel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rel && rel && req_kind == 2'b10) |-> !req_ready);
  assert_ack_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && ack_valid && !(req_valid && req_ready)) |=> (cnt == '0));
  assert_mem_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> !req_ready);
endmodule

bind ordgate ordgate_chk #(.MAX_OUT(MAX_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_rel  (mode_rel),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_ready (req_ready),
  .mem_ready (mem_ready),
  .ack_valid (ack_valid),
  .cnt       (cnt_q),
  .blk       (blk_q),
  .rel       (rel_q)
);

// File: tb/ordgate_tb.sv
module ordgate_tb;
  localparam int PER = 10;
  localparam int MAXO = 16;
  localparam int NV = 33;
  // vector: [7] mode [6] req_valid [5:4] kind [3] ack_valid [2:1] ack_kind [0] expected ready
  localparam logic [7:0] VEC [NV] = '{
    8'b0_1_00_0_00_1, 8'b0_1_00_0_00_1, 8'b0_1_01_0_00_0, 8'b0_1_01_1_00_0,
    8'b0_1_01_1_00_0, 8'b0_1_01_0_00_1, 8'b0_1_00_0_00_0, 8'b0_1_00_1_01_0,
    8'b0_1_00_0_00_1, 8'b0_1_10_0_00_0, 8'b0_1_10_1_00_0, 8'b0_1_10_0_00_1,
    8'b0_0_00_1_10_0,
    8'b1_1_00_0_00_1, 8'b1_1_10_0_00_1, 8'b1_1_00_0_00_0, 8'b1_1_00_1_10_0,
    8'b1_1_00_0_00_1, 8'b1_1_11_0_00_0, 8'b1_1_11_1_00_0, 8'b1_1_11_1_00_0,
    8'b1_1_11_0_00_1, 8'b1_1_00_0_00_1, 8'b1_1_10_0_00_0, 8'b1_1_10_1_11_0,
    8'b1_1_10_0_00_1, 8'b1_0_00_1_00_0, 8'b1_0_00_1_10_0, 8'b1_1_00_0_00_1,
    8'b1_0_00_1_00_1, 8'b1_0_00_1_00_1, 8'b1_1_01_0_00_1, 8'b1_0_00_1_01_0
  };

  logic clk, rst_n, mode_rel, req_valid, req_ready, iss_valid, mem_ready, ack_valid;
  logic [1:0] req_kind, iss_kind, ack_kind;
  int checks, errors;
  bit done;

  ordgate #(.MAX_OUT(MAXO)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_rel(mode_rel), .req_valid(req_valid),
    .req_kind(req_kind), .req_ready(req_ready), .iss_valid(iss_valid),
    .iss_kind(iss_kind), .mem_ready(mem_ready), .ack_valid(ack_valid),
    .ack_kind(ack_kind)
  );

  initial clk = 1'b0;
  always #(PER/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic rv, input logic [1:0] k,
                       input logic av, input logic [1:0] ak);
    @(negedge clk);
    mode_rel = m; req_valid = rv; req_kind = k; ack_valid = av; ack_kind = ak;
    #1;
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; mode_rel = 0; req_valid = 0; req_kind = 2'b01;
    mem_ready = 1; ack_valid = 0; ack_kind = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1: reset state accepts a sync at once, nothing offered without valid
    chk("R1 ready after reset", req_ready, 1'b1);
    chk("R1 no issue without valid", iss_valid, 1'b0);

    // R2 R3 R4 R5 R6 R7 R9: vector walk over both modes
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][7], VEC[i][6], VEC[i][5:4], VEC[i][3], VEC[i][2:1]);
      chk($sformatf("R2-R7 vector %0d ready", i), req_ready, VEC[i][0]);
      chk($sformatf("R10 vector %0d iss_valid", i), iss_valid, VEC[i][6] & VEC[i][0]);
    end
    drive(1, 0, 2'b00, 0, 2'b00);

    // R8: fill the counter to the limit with ordinary accesses
    for (int i = 0; i < MAXO; i++) begin
      drive(0, 1, 2'b00, 0, 2'b00);
      chk("R8 fill accepted", req_ready, 1'b1);
    end
    drive(0, 1, 2'b00, 0, 2'b00);
    chk("R8 full stalls", req_ready, 1'b0);
    drive(0, 0, 2'b00, 1, 2'b00);
    drive(0, 1, 2'b00, 0, 2'b00);
    chk("R8 one slot freed", req_ready, 1'b1);
    drive(0, 0, 2'b00, 0, 2'b00);
    for (int i = 0; i < MAXO; i++) drive(0, 0, 2'b00, 1, 2'b00);
    // R9: extra acks while empty are ignored, sync still accepted
    drive(0, 0, 2'b00, 1, 2'b00);
    drive(0, 0, 2'b00, 1, 2'b00);
    drive(0, 1, 2'b01, 0, 2'b00);
    chk("R9 count stayed zero", req_ready, 1'b1);
    drive(0, 0, 2'b00, 1, 2'b01);

    // R10: memory stall lowers ready but keeps the offer and kind
    drive(1, 1, 2'b11, 0, 2'b00);
    mem_ready = 0; #1;
    chk("R10 ready needs mem_ready", req_ready, 1'b0);
    chk("R10 offer held", iss_valid, 1'b1);
    chk("R10 kind passed", iss_kind == 2'b11, 1'b1);
    mem_ready = 1; #1;
    chk("R10 ready returns", req_ready, 1'b1);
    drive(1, 0, 2'b00, 0, 2'b00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule